// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block holds the digital control of a successive-approximation converter. A start pulse begins a conversion at 8, 10 or 12 bits of resolution. The conversion runs a fixed setup period, then a sample window, then a search that tests one bit at a time from the MSB downward. A closing overhead period follows the search. The sequencer drives a trial code to an external DAC and reads a single comparator bit back. The final code is copied into a held result register, and a one-cycle done pulse marks each transfer.

The block runs on a clock at twice the conversion-clock rate. One sequencer clock, called a tick, is therefore half a conversion-clock period. This lets the sample windows end on half-cycle boundaries. In continuous mode the next sample window starts directly after each transfer, and the setup period is skipped. Continuous mode stops when it is cleared or when the conversion is aborted. An abort stops the conversion at once and keeps the last result. A reset clears the result.

Top module: `sar_seq`

## Requirements
- R1: After reset, `busy`, `done`, `sampling`, `dac_code` and `result` are all zero. While idle, the block keeps `dac_code` at zero and `sampling` low until a start is accepted.
- R2: A `start` that is high in an idle cycle with `abort` low is accepted, and `busy` is high in the next tick. A `start` that arrives while busy is ignored, and the running conversion keeps its timing and result.
- R3: `sampling` stays high for 7 ticks (3.5 conversion-clock cycles) when `long_smp` is 0, and for 47 ticks (23.5 cycles) when it is 1. `long_smp` is captured when the conversion is accepted.
- R4: `res_sel` is captured at start and encodes 2'b00 = 8 bits, 2'b01 = 10 bits, 2'b10 or 2'b11 = 12 bits. `result` is the N-bit code, right-justified, with the bits above N zero.
- R5: During the search, `dac_code` is the right-justified trial code. It holds the bits decided so far plus the bit under test set to 1. Each bit uses two ticks, taken MSB first, and `cmp_in` is sampled in the second tick: 1 keeps the bit. Outside the search, `dac_code` is zero.
- R6: From the tick edge that accepts `start` to the edge that raises `done`, a conversion takes 40 ticks at 8 bits and 46 ticks at 10 or 12 bits with a short sample. With a long sample it takes 80 and 86 ticks.
- R7: Each later conversion in continuous mode takes 34 ticks at 8 bits and 40 ticks at 10 or 12 bits with a short sample. With a long sample it takes 74 and 80 ticks.
- R8: `done` is high for exactly one tick, in the same tick that `result` takes its new value. `result` does not change in any other tick.
- R9: `abort` during a conversion returns the block to idle in the next tick. No `done` follows, and `result` keeps the value from the last completed conversion.
- R10: Asserting `rst_n` low clears `result` to zero, even after a completed conversion.
- R11: If `cont` is cleared during a continuous conversion, that conversion still completes and transfers its result. The block is then idle on the following tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock, twice the conversion-clock rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Conversion request, accepted when idle |
| cont | input | 1 | Continuous mode: restart after each transfer |
| long_smp | input | 1 | Select the long sample window |
| res_sel | input | 2 | Resolution select (00 = 8, 01 = 10, 1x = 12 bits) |
| abort | input | 1 | Stop the conversion and return to idle |
| cmp_in | input | 1 | Comparator: 1 when the input is at or above the trial code |
| dac_code | output | 12 | Trial code to the DAC, zero outside the search |
| sampling | output | 1 | High while the input is being sampled |
| busy | output | 1 | High while a conversion is running |
| result | output | 12 | Held result of the last completed conversion |
| done | output | 1 | One-tick pulse when `result` is updated |

## Verification
All timing is counted from the tick edge that accepts `start`. The new result and the done pulse appear 40, 46, 80 or 86 ticks after that edge. In continuous mode, each later result follows the previous done by 34, 40, 74 or 80 ticks. A trial code for bit k appears 13 + 2·(N−1−k) ticks after the accepting edge. The bench drives inputs on falling edges and counts rising edges from the accepting edge, so each done pulse, sample window and trial code is read half a tick after the edge that produces it. Abort and reset effects are checked one tick after the stimulus. The absence of a done pulse is checked over a long window that follows.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;

    // Phases of one conversion, in the order they run.
    typedef enum logic [2:0] {
        PH_IDLE   = 3'd0,
        PH_SETUP  = 3'd1,
        PH_SAMPLE = 3'd2,
        PH_SEARCH = 3'd3,
        PH_TAIL   = 3'd4
    } phase_e;

    // Resolution encoding; both upper codes mean the widest mode.
    localparam logic [1:0] RES_LO  = 2'b00;
    localparam logic [1:0] RES_MID = 2'b01;

endpackage

// File: rtl/sar_seq_len.sv
// Phase lengths in ticks, chosen from the captured mode.
module sar_seq_len
    import sar_seq_pkg::*;
#(
    parameter int CNT_W    = 7,
    parameter int B_LO     = 8,
    parameter int B_MID    = 10,
    parameter int B_HI     = 12,
    parameter int SETUP_T  = 6,
    parameter int SHORT_T  = 7,
    parameter int LONG_T   = 47,
    parameter int TAIL_LO  = 11,
    parameter int TAIL_MID = 13,
    parameter int TAIL_HI  = 9
) (
    input  logic [1:0]       res_mode,
    input  logic             long_mode,
    output logic [CNT_W-1:0] setup_len,
    output logic [CNT_W-1:0] sample_len,
    output logic [CNT_W-1:0] search_len,
    output logic [CNT_W-1:0] tail_len
);

    localparam logic [CNT_W-1:0] SETUP_L  = CNT_W'(SETUP_T);
    localparam logic [CNT_W-1:0] SHORT_L  = CNT_W'(SHORT_T);
    localparam logic [CNT_W-1:0] LONG_L   = CNT_W'(LONG_T);
    localparam logic [CNT_W-1:0] SRCH_LO  = CNT_W'(2 * B_LO);
    localparam logic [CNT_W-1:0] SRCH_MID = CNT_W'(2 * B_MID);
    localparam logic [CNT_W-1:0] SRCH_HI  = CNT_W'(2 * B_HI);

    always_comb begin
        setup_len  = SETUP_L;
        sample_len = long_mode ? LONG_L : SHORT_L;
        case (res_mode)
            RES_LO: begin
                search_len = SRCH_LO;
                tail_len   = CNT_W'(TAIL_LO);
            end
            RES_MID: begin
                search_len = SRCH_MID;
                tail_len   = CNT_W'(TAIL_MID);
            end
            default: begin
                search_len = SRCH_HI;
                tail_len   = CNT_W'(TAIL_HI);
            end
        endcase
    end

endmodule

// File: rtl/sar_seq_fsm.sv
// Phase sequencing, tick counting, mode capture and the done pulse.
module sar_seq_fsm
    import sar_seq_pkg::*;
#(
    parameter int CNT_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             abort,
    input  logic             cont,
    input  logic [1:0]       res_sel,
    input  logic             long_smp,
    input  logic [CNT_W-1:0] setup_len,
    input  logic [CNT_W-1:0] sample_len,
    input  logic [CNT_W-1:0] search_len,
    input  logic [CNT_W-1:0] tail_len,
    output phase_e           phase,
    output logic [CNT_W-1:0] cnt,
    output logic [1:0]       res_mode,
    output logic             long_mode,
    output logic             latch,
    output logic             xfer,
    output logic             done
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    typedef struct packed {
        phase_e           phase;
        logic [CNT_W-1:0] cnt;
        logic [1:0]       mode;
        logic             lng;
        logic             done;
    } fsm_t;

    fsm_t s_q, s_d;

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        latch    = 1'b0;
        xfer     = 1'b0;
        case (s_q.phase)
            PH_IDLE: begin
                if (start) begin
                    s_d.phase = PH_SETUP;
                    s_d.cnt   = setup_len - ONE;
                    s_d.mode  = res_sel;
                    s_d.lng   = long_smp;
                end
            end
            PH_SETUP: begin
                if (s_q.cnt == '0) begin
                    s_d.phase = PH_SAMPLE;
                    s_d.cnt   = sample_len - ONE;
                end else begin
                    s_d.cnt = s_q.cnt - ONE;
                end
            end
            PH_SAMPLE: begin
                if (s_q.cnt == '0) begin
                    s_d.phase = PH_SEARCH;
                    s_d.cnt   = search_len - ONE;
                end else begin
                    s_d.cnt = s_q.cnt - ONE;
                end
            end
            PH_SEARCH: begin
                // second tick of each bit slot decides the bit
                latch = ~s_q.cnt[0];
                if (s_q.cnt == '0) begin
                    s_d.phase = PH_TAIL;
                    s_d.cnt   = tail_len - ONE;
                end else begin
                    s_d.cnt = s_q.cnt - ONE;
                end
            end
            PH_TAIL: begin
                if (s_q.cnt == '0) begin
                    xfer     = 1'b1;
                    s_d.done = 1'b1;
                    s_d.cnt  = sample_len - ONE;
                    s_d.phase = cont ? PH_SAMPLE : PH_IDLE;
                end else begin
                    s_d.cnt = s_q.cnt - ONE;
                end
            end
            default: s_d.phase = PH_IDLE;
        endcase
        if (abort) begin
            s_d.phase = PH_IDLE;
            s_d.cnt   = '0;
            s_d.done  = 1'b0;
            latch     = 1'b0;
            xfer      = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign phase     = s_q.phase;
    assign cnt       = s_q.cnt;
    assign res_mode  = s_q.mode;
    assign long_mode = s_q.lng;
    assign done      = s_q.done;

endmodule

// File: rtl/sar_seq_sar.sv
// Approximation register, trial code and held result.
module sar_seq_sar
    import sar_seq_pkg::*;
#(
    parameter int RES_W = 12,
    parameter int IDX_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  phase_e           phase,
    input  logic [IDX_W-1:0] bit_idx,
    input  logic             latch,
    input  logic             xfer,
    input  logic             cmp_in,
    output logic [RES_W-1:0] dac_code,
    output logic [RES_W-1:0] result
);

    localparam logic [RES_W-1:0] LSB = RES_W'(1);

    typedef struct packed {
        logic [RES_W-1:0] sar;
        logic [RES_W-1:0] res;
    } sar_t;

    sar_t s_q, s_d;
    logic [RES_W-1:0] trial;

    always_comb begin
        s_d   = s_q;
        trial = s_q.sar | (LSB << bit_idx);
        if (phase == PH_SAMPLE) s_d.sar = '0;
        if (latch && cmp_in)    s_d.sar = trial;
        if (xfer)               s_d.res = s_q.sar;
        dac_code = (phase == PH_SEARCH) ? trial : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign result = s_q.res;

endmodule

// File: rtl/sar_seq.sv
// Top: conversion sequencer of a successive-approximation converter.
module sar_seq
    import sar_seq_pkg::*;
#(
    parameter int RES_W    = 12,
    parameter int B_LO     = 8,
    parameter int B_MID    = 10,
    parameter int SETUP_T  = 6,
    parameter int SHORT_T  = 7,
    parameter int LONG_T   = 47,
    parameter int TAIL_LO  = 11,
    parameter int TAIL_MID = 13,
    parameter int TAIL_HI  = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             cont,
    input  logic             long_smp,
    input  logic [1:0]       res_sel,
    input  logic             abort,
    input  logic             cmp_in,
    output logic [RES_W-1:0] dac_code,
    output logic             sampling,
    output logic             busy,
    output logic [RES_W-1:0] result,
    output logic             done
);

    localparam int SPAN  = SETUP_T + LONG_T + 2 * RES_W + TAIL_MID + TAIL_LO + TAIL_HI;
    localparam int CNT_W = $clog2(SPAN + 1);
    localparam int IDX_W = CNT_W - 1;

    phase_e           phase;
    logic [CNT_W-1:0] cnt;
    logic [1:0]       res_mode;
    logic             long_mode;
    logic             latch;
    logic             xfer;
    logic [CNT_W-1:0] setup_len, sample_len, search_len, tail_len;

    sar_seq_len #(
        .CNT_W(CNT_W), .B_LO(B_LO), .B_MID(B_MID), .B_HI(RES_W),
        .SETUP_T(SETUP_T), .SHORT_T(SHORT_T), .LONG_T(LONG_T),
        .TAIL_LO(TAIL_LO), .TAIL_MID(TAIL_MID), .TAIL_HI(TAIL_HI)
    ) u_len (
        .res_mode   (res_mode),
        .long_mode  (long_mode),
        .setup_len  (setup_len),
        .sample_len (sample_len),
        .search_len (search_len),
        .tail_len   (tail_len)
    );

    sar_seq_fsm #(.CNT_W(CNT_W)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .abort      (abort),
        .cont       (cont),
        .res_sel    (res_sel),
        .long_smp   (long_smp),
        .setup_len  (setup_len),
        .sample_len (sample_len),
        .search_len (search_len),
        .tail_len   (tail_len),
        .phase      (phase),
        .cnt        (cnt),
        .res_mode   (res_mode),
        .long_mode  (long_mode),
        .latch      (latch),
        .xfer       (xfer),
        .done       (done)
    );

    sar_seq_sar #(.RES_W(RES_W), .IDX_W(IDX_W)) u_sar (
        .clk      (clk),
        .rst_n    (rst_n),
        .phase    (phase),
        .bit_idx  (cnt[CNT_W-1:1]),
        .latch    (latch),
        .xfer     (xfer),
        .cmp_in   (cmp_in),
        .dac_code (dac_code),
        .result   (result)
    );

    assign sampling = (phase == PH_SAMPLE);
    assign busy     = (phase != PH_IDLE);

endmodule

// File: rtl/sar_seq_chk.sv
// Port-level properties of the sequencer, bound onto every instance.
module sar_seq_chk #(
    parameter int RES_W = 12
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic             abort,
    input logic [RES_W-1:0] dac_code,
    input logic             sampling,
    input logic             busy,
    input logic [RES_W-1:0] result,
    input logic             done
);

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (dac_code == '0 && !sampling)); // R1

    AST_START_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && !abort) |=> busy); // R2

    AST_SAMPLE_NO_TRIAL: assert property (@(posedge clk) disable iff (!rst_n)
        sampling |-> dac_code == '0); // R5

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R8

    AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable(result)); // R8

    AST_DONE_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(busy)); // R8

    AST_ABORT_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
        (abort && busy) |=> (!busy && !done)); // R9

endmodule

bind sar_seq sar_seq_chk #(.RES_W(RES_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .abort    (abort),
    .dac_code (dac_code),
    .sampling (sampling),
    .busy     (busy),
    .result   (result),
    .done     (done)
);

// File: tb/sar_seq_bench.sv
`timescale 1ns/1ps
module sar_seq_bench;

    localparam int W = 12;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic         cont = 1'b0;
    logic         long_smp = 1'b0;
    logic         abort = 1'b0;
    logic [1:0]   res_sel = 2'b00;
    logic [W-1:0] vin = '0;
    logic         cmp_in;
    logic [W-1:0] dac_code;
    logic         sampling;
    logic         busy;
    logic [W-1:0] result;
    logic         done;

    int total = 0;
    int bad = 0;

    // behavioural comparator: ideal, input at or above the trial code
    assign cmp_in = (dac_code <= vin);

    always #2.5 clk = ~clk;

    sar_seq u_sar_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .cont(cont),
        .long_smp(long_smp), .res_sel(res_sel), .abort(abort),
        .cmp_in(cmp_in), .dac_code(dac_code), .sampling(sampling),
        .busy(busy), .result(result), .done(done)
    );

    typedef struct packed {
        logic [1:0]   mode;
        logic         lng;
        logic [W-1:0] vin;
        logic [W-1:0] exp;
        logic [7:0]   lat;
    } vec_t;

    localparam vec_t VECS [8] = '{
        '{2'd0, 1'b0, 12'h0A5, 12'h0A5, 8'd40},
        '{2'd0, 1'b1, 12'hFFF, 12'h0FF, 8'd80},
        '{2'd1, 1'b0, 12'h2C3, 12'h2C3, 8'd46},
        '{2'd1, 1'b1, 12'h5A0, 12'h3FF, 8'd86},
        '{2'd2, 1'b0, 12'hABC, 12'hABC, 8'd46},
        '{2'd2, 1'b1, 12'h000, 12'h000, 8'd86},
        '{2'd3, 1'b0, 12'h801, 12'h801, 8'd46},
        '{2'd0, 1'b0, 12'h001, 12'h001, 8'd40}
    };

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Ends half a tick after the edge that accepts the start.
    task automatic kick(input logic [1:0] m, input logic l, input logic [W-1:0] v);
        @(negedge clk);
        res_sel  = m;
        long_smp = l;
        vin      = v;
        start    = 1'b1;
        @(negedge clk);
        start    = 1'b0;
    endtask

    // Counts ticks until done is seen; also sample ticks and result stability.
    task automatic wait_done(output int lat, output int smp, output bit steady);
        logic [W-1:0] r0;
        r0     = result;
        lat    = 0;
        smp    = sampling ? 1 : 0;
        steady = 1'b1;
        for (int k = 0; k < 300; k++) begin
            @(posedge clk);
            @(negedge clk);
            lat++;
            if (done) break;
            if (sampling) smp++;
            if (result != r0) steady = 1'b0;
        end
    endtask

    initial begin
        #1000000;
        total++;
        bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int lat, smp, n;
        bit steady;
        logic [W-1:0] held;

        // R1 / R10: reset state
        repeat (3) @(negedge clk);
        chk(!busy && !done && !sampling, "R1 reset flags", {busy, done, sampling}, 0);
        chk(result == '0, "R10 reset result", result, 0);
        chk(dac_code == '0, "R1 reset dac", dac_code, 0);
        rst_n = 1'b1;
        repeat (6) @(negedge clk);
        chk(!busy && dac_code == '0 && !sampling, "R1 idle quiet", {busy, sampling}, 0);

        // table: one conversion per entry (R3, R4, R6, R8)
        for (int i = 0; i < 8; i++) begin
            kick(VECS[i].mode, VECS[i].lng, VECS[i].vin);
            wait_done(lat, smp, steady);
            chk(lat == int'(VECS[i].lat), "R6 first latency", lat, VECS[i].lat);
            chk(result == VECS[i].exp, "R4 result", result, VECS[i].exp);
            chk(smp == (VECS[i].lng ? 47 : 7), "R3 sample ticks", smp, VECS[i].lng ? 47 : 7);
            chk(steady, "R8 result held before done", 0, 1);
            @(negedge clk);
            chk(!done && !busy, "R8 done single tick", {done, busy}, 0);
        end

        // R5: trial code sequence, 12-bit, input 0xABC
        kick(2'd2, 1'b0, 12'hABC);
        n = 0;
        for (int k = 0; k < 46; k++) begin
            @(posedge clk);
            @(negedge clk);
            n++;
            if (n == 12) chk(dac_code == '0, "R5 no trial in sample", dac_code, 0);
            if (n == 13) chk(dac_code == 12'h800, "R5 trial msb", dac_code, 12'h800);
            if (n == 14) chk(dac_code == 12'h800, "R5 trial held two ticks", dac_code, 12'h800);
            if (n == 15) chk(dac_code == 12'hC00, "R5 trial bit10", dac_code, 12'hC00);
            if (n == 17) chk(dac_code == 12'hA00, "R5 trial bit9", dac_code, 12'hA00);
        end
        chk(done && result == 12'hABC, "R5 search result", result, 12'hABC);

        // R2: busy next tick, second start ignored
        kick(2'd0, 1'b0, 12'h033);
        chk(busy, "R2 busy after start", busy, 1);
        n = 0;
        for (int k = 0; k < 60; k++) begin
            @(posedge clk);
            @(negedge clk);
            n++;
            start   = (n == 10);
            res_sel = (n == 10) ? 2'd2 : 2'd0;
            if (done) break;
        end
        start = 1'b0;
        chk(n == 40, "R2 start while busy ignored", n, 40);
        chk(result == 12'h033, "R2 result kept", result, 12'h033);

        // R7 / R11: continuous, 8-bit short
        cont = 1'b1;
        kick(2'd0, 1'b0, 12'h037);
        wait_done(lat, smp, steady);
        chk(lat == 40, "R6 continuous first", lat, 40);
        vin = 12'h042;
        wait_done(lat, smp, steady);
        chk(lat == 34, "R7 8b short later", lat, 34);
        chk(result == 12'h042, "R7 later result", result, 12'h042);
        chk(smp == 7, "R3 later sample ticks", smp, 7);
        cont = 1'b0;
        wait_done(lat, smp, steady);
        chk(lat == 34, "R11 last conversion completes", lat, 34);
        chk(!busy, "R11 idle after last", busy, 0);
        repeat (5) @(negedge clk);
        chk(!busy && !done, "R11 stays idle", {busy, done}, 0);

        // R7: 10-bit short
        cont = 1'b1;
        kick(2'd1, 1'b0, 12'h155);
        wait_done(lat, smp, steady);
        cont = 1'b0;
        wait_done(lat, smp, steady);
        chk(lat == 40, "R7 10b short later", lat, 40);
        chk(result == 12'h155, "R7 10b result", result, 12'h155);

        // R7: 12-bit long
        cont = 1'b1;
        kick(2'd2, 1'b1, 12'h7FF);
        wait_done(lat, smp, steady);
        cont = 1'b0;
        wait_done(lat, smp, steady);
        chk(lat == 80, "R7 12b long later", lat, 80);
        chk(smp == 47, "R3 long later sample", smp, 47);

        // R7: 8-bit long
        cont = 1'b1;
        kick(2'd0, 1'b1, 12'h00C);
        wait_done(lat, smp, steady);
        cont = 1'b0;
        wait_done(lat, smp, steady);
        chk(lat == 74, "R7 8b long later", lat, 74);
        chk(result == 12'h00C, "R7 8b long result", result, 12'h00C);

        // R9: abort keeps the last result
        held = result;
        kick(2'd2, 1'b0, 12'h999);
        repeat (20) @(negedge clk);
        abort = 1'b1;
        @(negedge clk);
        abort = 1'b0;
        chk(!busy, "R9 idle after abort", busy, 0);
        steady = 1'b1;
        for (int k = 0; k < 100; k++) begin
            @(negedge clk);
            if (done || busy) steady = 1'b0;
        end
        chk(steady, "R9 no done after abort", 0, 1);
        chk(result == held, "R9 result kept", result, held);

        // R10: reset clears a nonzero result
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk(result == '0, "R10 reset clears result", result, 0);
        rst_n = 1'b1;
        @(negedge clk);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule